// File: doc/BRIEF.md
# Touch Conversion Sequencer with Pen Interrupt

This block sits behind the serial slave of a resistive touch-panel controller. When the slave latches the function nibble of a command byte it pulses `cmd_valid_i`. The block decodes the function code, the two power-down bits and the resolution bit. It then switches the panel drive transistors and selects the converter input. The acquisition phase starts at that point and lasts until the next bus STOP or repeated START, which arrives as `end_write_i`. The block then times the sample-and-convert periods in conversion-clock units and emits one `sample_start_o` strobe per period. A downstream median/average filter answers with `done_i` once the result is ready.

There are seven conversions per command when the filter is in use and a single conversion when a setup command has bypassed it. The block also owns the pen-touch interrupt. Acknowledging a write address masks the interrupt. A command whose power-down bit 0 is clear unmasks it again, but only after its conversion finishes. The interrupt output is held low whenever panel drivers other than the Y- ground switch are on. While idle and armed, the Y- switch grounds the panel and the interrupt follows the touch-sense comparator.

Top module: `touch_conv_seq`

## Requirements
- R1: After reset the X+, X- and Y+ enables, `sample_start_o`, `conv_pwr_o`, `fast_clk_o` and `chan_o` are 0. The interrupt is armed, so `yn_en_o` is 1 and `penirq_o` equals the inverse of `touch_i`.
- R2: Command byte fields are: function `cmd_i[7:4]`, power-down `cmd_i[3:2]` (bit 2 is PD0), resolution `cmd_i[1]` (1 = 8-bit). Driver and channel decode by function code:
  - 1100: X+/X- on, channel 3.
  - 1101: Y+/Y- on, channel 4.
  - 1110: X-/Y+ on, channel 4.
  - 1111: X-/Y+ on, channel 5.
  - 0000, 0010, 0100: no drivers, channels 0, 1, 2.
  - 1000: X+/X- on, no conversion.
  - 1001: Y+/Y- on, no conversion.
  - 1010: X-/Y+ on, no conversion.
- R3: From the cycle after a measuring command is latched until `end_write_i`, the selected drivers are on, `conv_pwr_o` is 1 and no `sample_start_o` is issued.
- R4: `fast_clk_o` equals the command's resolution bit. The first `sample_start_o` comes one cycle after `end_write_i`. Each period lasts CLKS×DIV cycles, where 12-bit uses 19 clocks with divider 2 and 8-bit uses 16 clocks with divider 1. The first period is 4 conversion clocks shorter because it overlaps the bus transfer.
- R5: A measuring command issues 7 strobes. After a setup command (code 1011) with `cmd_i[1]`=1 it issues 1 strobe; a setup command with `cmd_i[1]`=0 restores 7.
- R6: `conv_pwr_o` is 1 from command latch until the conversion is accepted as done. When idle it equals the last command's PD0.
- R7: `wr_addr_ack_i` disarms the interrupt (`penirq_o` high). A `done_i` accepted after the last period re-arms it and turns the drivers off when PD0=0. With PD0=1 the interrupt stays disarmed and the drivers stay on.
- R8: Whenever X+, X- or Y+ is enabled, `penirq_o` is low regardless of `touch_i`.
- R9: While idle, armed and with no other driver on, `yn_en_o` is 1 and `penirq_o` is low exactly when `touch_i` is 1.
- R10: A reserved code or the setup code starts no conversion and leaves drivers, channel, resolution and power-down state unchanged.
- R11: A new measuring or driver command during a conversion aborts it: the earlier strobes stop and the new command's sequence starts from its own `end_write_i`. A `done_i` before the last period has elapsed is ignored.
- R12: Driver-only commands keep their drivers on until the next command, and the `end_write_i` that follows them issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Command byte |
| cmd_valid_i | input | 1 | Function nibble latched strobe |
| end_write_i | input | 1 | STOP or repeated START after the command |
| wr_addr_ack_i | input | 1 | Write address acknowledged strobe |
| done_i | input | 1 | Filtered result ready strobe |
| touch_i | input | 1 | Touch-sense comparator, 1 = touched |
| xp_en_o | output | 1 | X+ drive enable |
| xn_en_o | output | 1 | X- drive enable |
| yp_en_o | output | 1 | Y+ drive enable |
| yn_en_o | output | 1 | Y- drive enable |
| chan_o | output | 3 | Converter input select |
| fast_clk_o | output | 1 | Converter clock-rate select, 1 = fast 8-bit rate |
| sample_start_o | output | 1 | Start of one sample-and-convert period |
| conv_pwr_o | output | 1 | Converter powered |
| penirq_o | output | 1 | Pen interrupt, active low |

## Verification
Position, temperature and auxiliary commands are run at both resolutions and under both filter settings. This separates the 7-strobe from the 1-strobe sequence and the 38/30-cycle spacing from the 16/12-cycle spacing. PD0 set and clear is tried with the panel touched and untouched, which tells a re-armed interrupt apart from one that is masked or forced low. A reserved code, driver-only commands and an abort with an early `done_i` check that nothing moves unless it should.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {K_NONE, K_SETUP, K_DRIVE, K_MEAS} kind_e;

  localparam int unsigned DRV_XP = 0;
  localparam int unsigned DRV_XN = 1;
  localparam int unsigned DRV_YP = 2;
  localparam int unsigned DRV_YN = 3;

  typedef struct packed {
    kind_e       kind;
    logic [3:0]  drv;
    logic [2:0]  chan;
  } dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_RUN} st_e;
endpackage

// File: rtl/tsq_decode.sv
module tsq_decode
  import tsq_pkg::*;
(
  input  logic [3:0] func_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '{kind: K_NONE, drv: 4'b0000, chan: 3'd0};
    unique case (func_i)
      4'b0000: dec_o = '{kind: K_MEAS,  drv: 4'b0000, chan: 3'd0};
      4'b0010: dec_o = '{kind: K_MEAS,  drv: 4'b0000, chan: 3'd1};
      4'b0100: dec_o = '{kind: K_MEAS,  drv: 4'b0000, chan: 3'd2};
      4'b1000: dec_o = '{kind: K_DRIVE, drv: 4'b0011, chan: 3'd0};
      4'b1001: dec_o = '{kind: K_DRIVE, drv: 4'b1100, chan: 3'd0};
      4'b1010: dec_o = '{kind: K_DRIVE, drv: 4'b0110, chan: 3'd0};
      4'b1011: dec_o = '{kind: K_SETUP, drv: 4'b0000, chan: 3'd0};
      4'b1100: dec_o = '{kind: K_MEAS,  drv: 4'b0011, chan: 3'd3};
      4'b1101: dec_o = '{kind: K_MEAS,  drv: 4'b1100, chan: 3'd4};
      4'b1110: dec_o = '{kind: K_MEAS,  drv: 4'b0110, chan: 3'd4};
      4'b1111: dec_o = '{kind: K_MEAS,  drv: 4'b0110, chan: 3'd5};
      default: dec_o = '{kind: K_NONE,  drv: 4'b0000, chan: 3'd0};
    endcase
  end
endmodule

// File: rtl/tsq_timer.sv
module tsq_timer #(
  parameter int unsigned CLKS_HI = 19,
  parameter int unsigned CLKS_LO = 16,
  parameter int unsigned DIV_HI  = 2,
  parameter int unsigned DIV_LO  = 1,
  parameter int unsigned OVERLAP = 4,
  parameter int unsigned NW      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          fast_i,
  input  logic [NW-1:0] nconv_i,
  output logic          busy_o,
  output logic          sample_o
);
  localparam int unsigned LEN_HI   = CLKS_HI * DIV_HI;
  localparam int unsigned LEN_LO   = CLKS_LO * DIV_LO;
  localparam int unsigned FIRST_HI = (CLKS_HI - OVERLAP) * DIV_HI;
  localparam int unsigned FIRST_LO = (CLKS_LO - OVERLAP) * DIV_LO;
  localparam int unsigned LEN_MAX  = (LEN_HI > LEN_LO) ? LEN_HI : LEN_LO;
  localparam int unsigned CW       = $clog2(LEN_MAX + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q, last_cnt;
  logic [NW-1:0] idx_q;

  always_comb begin
    if (idx_q == '0) last_cnt = fast_i ? CW'(FIRST_LO - 1) : CW'(FIRST_HI - 1);
    else             last_cnt = fast_i ? CW'(LEN_LO - 1)   : CW'(LEN_HI - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == last_cnt) begin
        cnt_q <= '0;
        if (idx_q == nconv_i - NW'(1)) busy_q <= 1'b0;
        else                           idx_q  <= idx_q + NW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign sample_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/tsq_pen.sv
module tsq_pen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disarm_i,
  input  logic arm_i,
  input  logic force_low_i,
  input  logic touch_i,
  output logic armed_o,
  output logic penirq_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b1;
    else if (disarm_i) armed_q <= 1'b0;
    else if (arm_i)    armed_q <= 1'b1;
  end

  assign armed_o  = armed_q;
  assign penirq_o = force_low_i ? 1'b0 : (armed_q ? !touch_i : 1'b1);
endmodule

// File: rtl/touch_conv_seq.sv
module touch_conv_seq
  import tsq_pkg::*;
#(
  parameter int unsigned CLKS_HI = 19,
  parameter int unsigned CLKS_LO = 16,
  parameter int unsigned DIV_HI  = 2,
  parameter int unsigned DIV_LO  = 1,
  parameter int unsigned OVERLAP = 4,
  parameter int unsigned FILT_N  = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cmd_i,
  input  logic       cmd_valid_i,
  input  logic       end_write_i,
  input  logic       wr_addr_ack_i,
  input  logic       done_i,
  input  logic       touch_i,
  output logic       xp_en_o,
  output logic       xn_en_o,
  output logic       yp_en_o,
  output logic       yn_en_o,
  output logic [2:0] chan_o,
  output logic       fast_clk_o,
  output logic       sample_start_o,
  output logic       conv_pwr_o,
  output logic       penirq_o
);
  localparam int unsigned NW = $clog2(FILT_N + 1);

  st_e        st_q;
  dec_t       dec;
  logic [3:0] drv_q;
  logic [2:0] chan_q;
  logic [1:0] pd_q;
  logic       fast_q, byp_q;
  logic       cmd_take, setup_take, run_go, done_take;
  logic       tmr_busy, armed, force_low;
  logic [NW-1:0] nconv;
  logic       unused_pullup_bit;

  assign unused_pullup_bit = cmd_i[0];

  tsq_decode i_dec (.func_i(cmd_i[7:4]), .dec_o(dec));

  assign cmd_take   = cmd_valid_i && (dec.kind == K_MEAS || dec.kind == K_DRIVE);
  assign setup_take = cmd_valid_i && (dec.kind == K_SETUP);
  assign run_go     = !cmd_take && end_write_i && (st_q == ST_ACQ);
  assign done_take  = !cmd_take && done_i && (st_q == ST_RUN) && !tmr_busy;
  assign nconv      = byp_q ? NW'(1) : NW'(FILT_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      drv_q  <= '0;
      chan_q <= '0;
      pd_q   <= '0;
      fast_q <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      if (setup_take) byp_q <= cmd_i[1];
      if (cmd_take) begin
        drv_q  <= dec.drv;
        pd_q   <= cmd_i[3:2];
        fast_q <= cmd_i[1];
        if (dec.kind == K_MEAS) begin
          chan_q <= dec.chan;
          st_q   <= ST_ACQ;
        end else begin
          st_q   <= ST_IDLE;
        end
      end else if (run_go) begin
        st_q <= ST_RUN;
      end else if (done_take) begin
        st_q <= ST_IDLE;
        if (!pd_q[0]) drv_q <= '0;
      end
    end
  end

  tsq_timer #(
    .CLKS_HI(CLKS_HI), .CLKS_LO(CLKS_LO), .DIV_HI(DIV_HI), .DIV_LO(DIV_LO),
    .OVERLAP(OVERLAP), .NW(NW)
  ) i_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (run_go),
    .abort_i  (cmd_take),
    .fast_i   (fast_q),
    .nconv_i  (nconv),
    .busy_o   (tmr_busy),
    .sample_o (sample_start_o)
  );

  assign force_low = drv_q[DRV_XP] | drv_q[DRV_XN] | drv_q[DRV_YP];

  tsq_pen i_pen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .disarm_i    (wr_addr_ack_i),
    .arm_i       (done_take && !pd_q[0]),
    .force_low_i (force_low),
    .touch_i     (touch_i),
    .armed_o     (armed),
    .penirq_o    (penirq_o)
  );

  assign xp_en_o    = drv_q[DRV_XP];
  assign xn_en_o    = drv_q[DRV_XN];
  assign yp_en_o    = drv_q[DRV_YP];
  assign yn_en_o    = drv_q[DRV_YN] | ((st_q == ST_IDLE) && armed && (drv_q == '0));
  assign chan_o     = chan_q;
  assign fast_clk_o = fast_q;
  assign conv_pwr_o = (st_q != ST_IDLE) || pd_q[0];
endmodule

// File: rtl/tsq_chk.sv
module tsq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic wr_addr_ack_i,
  input logic xp_en_o,
  input logic xn_en_o,
  input logic yp_en_o,
  input logic yn_en_o,
  input logic fast_clk_o,
  input logic sample_start_o,
  input logic conv_pwr_o,
  input logic penirq_o
);
  // R8
  force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xp_en_o || xn_en_o || yp_en_o) |-> !penirq_o);

  // R2
  no_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xp_en_o && yp_en_o) && !(xn_en_o && yn_en_o) && !(xp_en_o && yn_en_o));

  // R7
  ack_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_ack_i && !cmd_valid_i) |=> (penirq_o || xp_en_o || xn_en_o || yp_en_o));

  // R6
  pwr_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_start_o |-> conv_pwr_o);

  // R4
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_start_o |=> !sample_start_o);

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(fast_clk_o));
endmodule

bind touch_conv_seq tsq_chk i_tsq_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .wr_addr_ack_i  (wr_addr_ack_i),
  .xp_en_o        (xp_en_o),
  .xn_en_o        (xn_en_o),
  .yp_en_o        (yp_en_o),
  .yn_en_o        (yn_en_o),
  .fast_clk_o     (fast_clk_o),
  .sample_start_o (sample_start_o),
  .conv_pwr_o     (conv_pwr_o),
  .penirq_o       (penirq_o)
);

// File: tb/test_touch_conv_seq.sv
module test_touch_conv_seq;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] cmd_i = '0;
  logic cmd_valid_i = 0, end_write_i = 0, wr_addr_ack_i = 0, done_i = 0, touch_i = 0;
  logic xp_en_o, xn_en_o, yp_en_o, yn_en_o, fast_clk_o, sample_start_o, conv_pwr_o, penirq_o;
  logic [2:0] chan_o;

  always #2 clk_i = ~clk_i;

  touch_conv_seq i_touch_conv_seq (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model
  int cyc = 0, ph = 0, m_end = 0, m_chan = 0, nsamp = 0;
  int q[$];
  bit m_pen = 1, m_mode = 0, m_byp = 0, m_wt = 0;
  bit [1:0] m_pd = 0;
  bit [3:0] m_drv = 0;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit e_s, old_wt, e_yn, e_irq, meas, drive;
      bit [3:0] f, d;
      int ch, s, first, full, n;
      cyc++;
      old_wt = (ph == 2) && (cyc - 1 >= m_end);
      f = cmd_i[7:4];
      meas = 0; drive = 0; d = 0; ch = 0;
      case (f)
        4'h0: begin meas = 1; ch = 0; end
        4'h2: begin meas = 1; ch = 1; end
        4'h4: begin meas = 1; ch = 2; end
        4'hC: begin meas = 1; ch = 3; d = 4'b0011; end
        4'hD: begin meas = 1; ch = 4; d = 4'b1100; end
        4'hE: begin meas = 1; ch = 4; d = 4'b0110; end
        4'hF: begin meas = 1; ch = 5; d = 4'b0110; end
        4'h8: begin drive = 1; d = 4'b0011; end
        4'h9: begin drive = 1; d = 4'b1100; end
        4'hA: begin drive = 1; d = 4'b0110; end
        default: ;
      endcase
      if (wr_addr_ack_i) m_pen = 0;
      if (cmd_valid_i && (meas || drive)) begin
        q.delete();
        m_mode = cmd_i[1]; m_pd = cmd_i[3:2]; m_drv = d;
        if (meas) begin m_chan = ch; ph = 1; end else ph = 0;
      end else if (cmd_valid_i && f == 4'hB) begin
        m_byp = cmd_i[1];
      end else if (end_write_i && ph == 1) begin
        ph = 2;
        first = m_mode ? 12 : 30;
        full  = m_mode ? 16 : 38;
        n = m_byp ? 1 : 7;
        s = cyc;
        for (int i = 0; i < n; i++) begin
          q.push_back(s);
          s += (i == 0) ? first : full;
        end
        m_end = s;
      end else if (done_i && old_wt) begin
        ph = 0;
        if (!m_pd[0]) begin m_pen = 1; m_drv = 0; end
      end
      e_s = 0;
      if (q.size() > 0 && q[0] == cyc) begin e_s = 1; void'(q.pop_front()); end
      m_wt = (ph == 2) && (cyc >= m_end);
      e_yn = m_drv[3] | (ph == 0 && m_pen && m_drv == 0);
      e_irq = (|m_drv[2:0]) ? 1'b0 : (m_pen ? !touch_i : 1'b1);
      #1;
      if (sample_start_o) nsamp++;
      chk(sample_start_o == e_s, "R4", "sample_start_o", sample_start_o, e_s);
      chk({yn_en_o, yp_en_o, xn_en_o, xp_en_o} == {e_yn, m_drv[2:0]}, "R2",
          "drivers", {yn_en_o, yp_en_o, xn_en_o, xp_en_o}, {e_yn, m_drv[2:0]});
      chk(chan_o == m_chan, "R2", "chan_o", chan_o, m_chan);
      chk(fast_clk_o == m_mode, "R4", "fast_clk_o", fast_clk_o, m_mode);
      chk(conv_pwr_o == ((ph != 0) || m_pd[0]), "R6", "conv_pwr_o", conv_pwr_o,
          (ph != 0) || m_pd[0]);
      chk(penirq_o == e_irq, "R9", "penirq_o", penirq_o, e_irq);
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk_i); sig = 1;
    @(negedge clk_i); sig = 0;
  endtask

  task automatic write_cmd(logic [7:0] c, bit ew);
    pulse(wr_addr_ack_i);
    repeat (2) @(negedge clk_i);
    cmd_i = c;
    pulse(cmd_valid_i);
    repeat (3) @(negedge clk_i);
    if (ew) pulse(end_write_i);
  endtask

  task automatic finish_conv();
    wait (m_wt);
    repeat (2) @(negedge clk_i);
    pulse(done_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk({xp_en_o, xn_en_o, yp_en_o, sample_start_o, conv_pwr_o, fast_clk_o} == 0 && chan_o == 0,
        "R1", "reset outputs", {xp_en_o, xn_en_o, yp_en_o, conv_pwr_o}, 0);
    chk(yn_en_o && penirq_o, "R1", "yn/penirq at reset", {yn_en_o, penirq_o}, 3);
    touch_i = 1; @(negedge clk_i);
    chk(!penirq_o, "R9", "touched idle penirq", penirq_o, 0);
    touch_i = 0; @(negedge clk_i);

    // X, 12-bit, PD=00, filter on
    base = nsamp;
    write_cmd(8'hC0, 1);
    finish_conv();
    chk(nsamp - base == 7, "R5", "strobes filtered", nsamp - base, 7);
    touch_i = 1; @(negedge clk_i);
    chk(!penirq_o && yn_en_o, "R7", "re-armed penirq", penirq_o, 0);
    touch_i = 0;

    // Y, 8-bit, PD=01
    base = nsamp;
    write_cmd(8'hD6, 1);
    finish_conv();
    chk(nsamp - base == 7, "R5", "strobes 8-bit", nsamp - base, 7);
    chk(yp_en_o && conv_pwr_o, "R7", "drivers kept with PD0=1", yp_en_o, 1);
    chk(!penirq_o, "R8", "forced low touch=0", penirq_o, 0);

    // bypass then TEMP1 PD=10
    write_cmd(8'hB2, 1);
    base = nsamp;
    write_cmd(8'h48, 1);
    finish_conv();
    chk(nsamp - base == 1, "R5", "strobes bypassed", nsamp - base, 1);
    chk(!conv_pwr_o, "R6", "idle power PD=10", conv_pwr_o, 0);
    chk(penirq_o == 1, "R7", "re-armed untouched", penirq_o, 1);

    // reserved code
    base = nsamp;
    write_cmd(8'h1E, 1);
    repeat (10) @(negedge clk_i);
    chk(nsamp == base && chan_o == 2 && !fast_clk_o && !conv_pwr_o, "R10",
        "reserved code effect", chan_o, 2);

    // driver only
    base = nsamp;
    write_cmd(8'hA0, 1);
    repeat (20) @(negedge clk_i);
    chk(nsamp == base, "R12", "driver-only strobes", nsamp - base, 0);
    chk(xn_en_o && yp_en_o && !penirq_o, "R8", "driver-only force low",
        {xn_en_o, yp_en_o, penirq_o}, 6);

    // AUX acquisition window
    write_cmd(8'hB0, 0);
    write_cmd(8'h20, 0);
    repeat (5) @(negedge clk_i);
    chk(conv_pwr_o && !sample_start_o && chan_o == 1, "R3", "acquisition", conv_pwr_o, 1);
    pulse(end_write_i);
    finish_conv();

    // abort
    write_cmd(8'hE0, 1);
    repeat (50) @(negedge clk_i);
    pulse(done_i);
    base = nsamp;
    write_cmd(8'hF2, 0);
    repeat (20) @(negedge clk_i);
    chk(nsamp == base, "R11", "aborted strobes", nsamp - base, 0);
    pulse(end_write_i);
    finish_conv();
    chk(nsamp - base == 7, "R11", "restarted strobes", nsamp - base, 7);
    chk(chan_o == 5 && fast_clk_o, "R11", "new command applied", chan_o, 5);

    repeat (5) @(negedge clk_i);
    report();
  end
endmodule